// File: doc/BRIEF.md
# Watch Timer with Buzzer Output

This block is a real-time interval timer with a square-wave tone output. Software writes an 8-bit mode register to choose the timer clock, the interrupt interval and the tone frequency, and to start or stop the timer. The timer clock is either the main clock divided by 128 or a slow subsystem clock. In both cases the timer-clock edge becomes a one-cycle enable in the main clock domain, so every register in the block runs on the main clock.

A single binary divider chain advances once per timer tick. Its low bits give the four buzzer taps, and its full or short terminal count gives the interrupt interval. The timer clock is taken as nominally 32.768 kHz. At that rate the normal interval is 16384 ticks (half a second) and the fast interval is 128 ticks (about 3.9 ms). Stopping the timer resets both the chain and the main-clock prescaler.

One bit of the register cannot be written. It reads back the synchronised level of the subsystem oscillator pin, so after reset it shows the pin level and every other bit reads zero.

Top module: `watch_timer`

## Requirements
- R1: After reset the register reads 0x00 with bit 3 replaced by the oscillator pin level (0x08 when the pin is high).
- R2: Bit 6 always reads 0. Bits 7, 5, 4, 2, 1 and 0 read back the last written value. Writes to bits 3 and 6 are ignored.
- R3: Bit 3 reads the oscillator pin level through a two-stage synchroniser. A pin change is visible after the second rising clock edge and not after the first.
- R4: Bit 0 selects the timer tick. At 0 a tick is every 128th main-clock cycle. At 1 a tick is each rising edge of the subsystem clock input.
- R5: With bit 1 at 0 and bit 2 at 1, the interrupt output pulses once per 16384 timer ticks, the first pulse coming 16384 ticks after the timer is enabled.
- R6: With bit 1 at 1 and bit 2 at 1, the interrupt output pulses once per 128 timer ticks.
- R7: Each interrupt pulse lasts exactly one main-clock cycle.
- R8: Bit 2 at 0 stops the timer, clears the divider chain and the prescaler, and keeps the interrupt output low. After re-enabling, the first interrupt comes one full interval later.
- R9: Bits 5:4 select the buzzer period in timer ticks: 00 gives 16 ticks, 01 gives 8, 10 gives 4 and 11 gives 2, with a 50 % duty cycle.
- R10: The buzzer output is low whenever bit 7 or bit 2 is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Mode register write strobe |
| reg_wdata | input | 8 | Mode register write data |
| reg_rdata | output | 8 | Mode register read value |
| sub_clk | input | 1 | Subsystem clock, asynchronous to clk |
| osc_pin | input | 1 | Level of the subsystem oscillator input pin |
| irq_o | output | 1 | Interval interrupt request, one-cycle pulse |
| buzz_o | output | 1 | Buzzer square-wave output |

## Verification
The assertions assume three things about the inputs. Reset is held for at least two clock cycles, so the pin synchroniser is filled before any check is enabled. The subsystem clock stays high and low for at least two main-clock cycles each, so that every rising edge yields exactly one tick. The oscillator pin changes at most once per cycle, away from the clock edge. The stimulus drives the subsystem clock with a four-cycle period and changes all inputs on the falling clock edge. The random register writes always pick the subsystem clock as the tick source, which keeps buzzer and interval measurements short.

// File: rtl/wt_pkg.sv
package wt_pkg;

  typedef struct packed {
    logic       buz_en;
    logic [1:0] buz_sel;
    logic       run;
    logic       fast;
    logic       src_sub;
  } wt_mode_t;

  // Chain bit that drives the buzzer: higher select means a lower tap.
  function automatic int unsigned buzz_tap(input int unsigned top, input logic [1:0] sel);
    return top - int'(sel);
  endfunction

  // Buzzer period in ticks for a given tap.
  function automatic int unsigned buzz_period(input int unsigned tap);
    return 2 << tap;
  endfunction

  // Pack the mode fields and the pin level into the read value.
  function automatic logic [7:0] pack_read(input wt_mode_t m, input logic pin);
    return {m.buz_en, 1'b0, m.buz_sel, pin, m.run, m.fast, m.src_sub};
  endfunction

endpackage

// File: rtl/wt_modereg.sv
module wt_modereg
  import wt_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [7:0]     wdata,
  input  logic           osc_pin,
  output wt_mode_t       mode,
  output logic           pin_lvl,
  output logic [7:0]     rdata
);

  logic pin_s1;
  logic pin_s2;

  // The synchroniser runs through reset, so bit 3 is settled when reset lifts.
  always_ff @(posedge clk) begin
    pin_s1 <= osc_pin;
    pin_s2 <= pin_s1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (we) begin
      mode.buz_en  <= wdata[7];
      mode.buz_sel <= wdata[5:4];
      mode.run     <= wdata[2];
      mode.fast    <= wdata[1];
      mode.src_sub <= wdata[0];
    end
  end

  assign pin_lvl = pin_s2;
  assign rdata   = pack_read(mode, pin_s2);

endmodule

// File: rtl/wt_tick_gen.sv
module wt_tick_gen #(
  parameter int unsigned PRE_DIV = 128
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic src_sub,
  input  logic sub_clk,
  output logic sub_edge,
  output logic pre_done,
  output logic tick_en
);

  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] pre_cnt;
  logic [2:0]       sub_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) sub_sync <= '0;
    else        sub_sync <= {sub_sync[1:0], sub_clk};
  end

  assign sub_edge = sub_sync[1] & ~sub_sync[2];

  always_ff @(posedge clk) begin
    if (!rst_n || !run)          pre_cnt <= '0;
    else if (pre_cnt == PRE_LAST) pre_cnt <= '0;
    else                          pre_cnt <= pre_cnt + 1'b1;
  end

  assign pre_done = run & (pre_cnt == PRE_LAST);
  assign tick_en  = run & (src_sub ? sub_edge : pre_done);

endmodule

// File: rtl/wt_divider.sv
module wt_divider
  import wt_pkg::*;
#(
  parameter int unsigned CHAIN_W = 14,
  parameter int unsigned FAST_W  = 7,
  parameter int unsigned TAP_TOP = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick_en,
  input  logic               fast,
  input  logic               buz_en,
  input  logic [1:0]         buz_sel,
  output logic [CHAIN_W-1:0] chain,
  output logic               terminal,
  output logic               irq,
  output logic               buzz
);

  int unsigned tap;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) chain <= '0;
    else if (tick_en)   chain <= chain + 1'b1;
  end

  generate
    if (FAST_W < CHAIN_W) begin : g_two_speed
      assign terminal = fast ? (&chain[FAST_W-1:0]) : (&chain);
    end else begin : g_one_speed
      assign terminal = &chain;
    end
  endgenerate

  always_comb tap = buzz_tap(TAP_TOP, buz_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      buzz <= 1'b0;
    end else begin
      irq  <= tick_en & terminal;
      buzz <= run & buz_en & chain[tap];
    end
  end

endmodule

// File: rtl/watch_timer.sv
module watch_timer
  import wt_pkg::*;
#(
  parameter int unsigned PRE_DIV = 128,
  parameter int unsigned CHAIN_W = 14,
  parameter int unsigned FAST_W  = 7,
  parameter int unsigned TAP_TOP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sub_clk,
  input  logic       osc_pin,
  output logic       irq_o,
  output logic       buzz_o
);

  wt_mode_t           mode;
  logic               pin_lvl;
  logic               sub_edge;
  logic               pre_done;
  logic               tick_en;
  logic [CHAIN_W-1:0] chain_w;
  logic               terminal_w;

  wt_modereg u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .wdata   (reg_wdata),
    .osc_pin (osc_pin),
    .mode    (mode),
    .pin_lvl (pin_lvl),
    .rdata   (reg_rdata)
  );

  wt_tick_gen #(.PRE_DIV(PRE_DIV)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mode.run),
    .src_sub  (mode.src_sub),
    .sub_clk  (sub_clk),
    .sub_edge (sub_edge),
    .pre_done (pre_done),
    .tick_en  (tick_en)
  );

  wt_divider #(
    .CHAIN_W (CHAIN_W),
    .FAST_W  (FAST_W),
    .TAP_TOP (TAP_TOP)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (mode.run),
    .tick_en  (tick_en),
    .fast     (mode.fast),
    .buz_en   (mode.buz_en),
    .buz_sel  (mode.buz_sel),
    .chain    (chain_w),
    .terminal (terminal_w),
    .irq      (irq_o),
    .buzz     (buzz_o)
  );

endmodule

// File: rtl/watch_timer_chk.sv
module watch_timer_chk #(
  parameter int unsigned CHAIN_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               osc_pin,
  input logic [7:0]         rdata,
  input logic               irq_o,
  input logic               buzz_o,
  input logic [CHAIN_W-1:0] chain
);

  // R2: bit 6 of the read value is never set
  p_bit6_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[6] == 1'b0);

  // R3: bit 3 follows the pin two edges later
  p_pin_mirror_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[3] == $past(osc_pin, 2));

  // R7: interrupt is a single-cycle pulse
  p_irq_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R8: a stopped timer raises no interrupt
  p_stop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[2] |=> !irq_o);

  // R8: a stopped timer holds the chain at zero
  p_stop_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata[2] |=> (chain == '0));

  // R10: buzzer silent unless both enables are set
  p_buzz_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(rdata[7] && rdata[2]) |=> !buzz_o);

endmodule

bind watch_timer watch_timer_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .osc_pin (osc_pin),
  .rdata   (reg_rdata),
  .irq_o   (irq_o),
  .buzz_o  (buzz_o),
  .chain   (chain_w)
);

// File: tb/test_watch_timer.sv
module test_watch_timer;

  localparam int CLK_PERIOD = 10;
  localparam int SUB_HALF   = 2;            // main cycles per subsystem half period
  localparam int SUB_CYC    = 2 * SUB_HALF; // main cycles per subsystem tick
  localparam longint WATCHDOG = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       sub_clk = 1'b0;
  logic       osc_pin = 1'b0;
  logic       irq_o;
  logic       buzz_o;

  int     n_checks = 0;
  int     n_fail   = 0;
  longint cyc      = 0;
  bit     done     = 1'b0;

  watch_timer i_watch_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sub_clk   (sub_clk),
    .osc_pin   (osc_pin),
    .irq_o     (irq_o),
    .buzz_o    (buzz_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    forever begin
      repeat (SUB_HALF) @(negedge clk);
      sub_clk = ~sub_clk;
    end
  end

  function automatic logic [7:0] exp_read(input logic [7:0] d, input logic pin);
    return (d & 8'hB7) | {4'b0, pin, 3'b0};
  endfunction

  function automatic longint exp_buzz_cycles(input logic [1:0] sel);
    return longint'(16 >> sel) * SUB_CYC;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Wait at most lim cycles for an interrupt; returns its cycle or -1.
  task automatic wait_irq(input longint lim, output longint at);
    at = -1;
    for (longint k = 0; k < lim; k++) begin
      @(negedge clk);
      if (irq_o) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic wait_buzz_rise(input longint lim, output longint at);
    logic prev;
    at = -1;
    prev = buzz_o;
    for (longint k = 0; k < lim; k++) begin
      @(negedge clk);
      if (buzz_o && !prev) begin
        at = cyc;
        break;
      end
      prev = buzz_o;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= WATCHDOG);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
    summary();
  end

  initial begin
    longint t0, t1, t2;
    logic [7:0] d;
    bit quiet;
    void'($urandom(32'h5EED_0C1D));

    // R1: reset with pin high
    osc_pin = 1'b1;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 8'h08, "R1 reset pin high", reg_rdata, 8'h08);
    wr(8'hFF);
    // R1: reset with pin low clears everything
    osc_pin = 1'b0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(reg_rdata == 8'h00, "R1 reset pin low", reg_rdata, 8'h00);

    // R3: synchroniser latency
    osc_pin = 1'b1;
    @(negedge clk);
    check(reg_rdata[3] == 1'b0, "R3 after one edge", reg_rdata[3], 0);
    @(negedge clk);
    check(reg_rdata[3] == 1'b1, "R3 after two edges", reg_rdata[3], 1);

    // R2: bits 3 and 6 ignore writes
    wr(8'h48);
    osc_pin = 1'b0;
    repeat (3) @(negedge clk);
    check(reg_rdata == 8'h00, "R2 bits 3 and 6 ignored", reg_rdata, 8'h00);

    // R4 + R6: fast interval from main clock /128, first pulse after 128*128 cycles
    wr(8'h06);
    t0 = cyc;
    wait_irq(20000, t1);
    check(t1 >= 0 && (t1 - t0) >= 16384 - 4 && (t1 - t0) <= 16384 + 4,
          "R4 main/128 tick source", t1 - t0, 16384);
    @(negedge clk);
    check(irq_o == 1'b0, "R7 pulse width main", irq_o, 0);

    // R6: fast interval from subsystem ticks, pulse spacing
    wr(8'h07);
    wait_irq(2000, t1);
    wait_irq(2000, t2);
    check(t1 >= 0 && t2 >= 0 && (t2 - t1) == 128 * SUB_CYC,
          "R6 fast spacing", t2 - t1, 128 * SUB_CYC);

    // R8: stop keeps irq and buzzer low, restart gives a full interval
    wr(8'hB3);
    quiet = 1'b1;
    for (int k = 0; k < 700; k++) begin
      @(negedge clk);
      if (irq_o || buzz_o) quiet = 1'b0;
    end
    check(quiet, "R8 stopped is quiet", !quiet, 0);
    wr(8'h07);
    t0 = cyc;
    wait_irq(2000, t1);
    check(t1 >= 0 && (t1 - t0) >= 128 * SUB_CYC - 6 && (t1 - t0) <= 128 * SUB_CYC + 6,
          "R8 restart interval", t1 - t0, 128 * SUB_CYC);

    // R9/R10/R2: constrained random mode writes, subsystem source always
    for (int it = 0; it < 16; it++) begin
      d = 8'($urandom) | 8'h01;
      if (it < 4) d = {1'b1, 1'b0, 2'(it), 4'b0101};
      osc_pin = 1'($urandom);
      wr(d);
      @(negedge clk);
      check(reg_rdata == exp_read(d, osc_pin), "R2 readback",
            reg_rdata, exp_read(d, osc_pin));
      if (d[7] && d[2]) begin
        wait_buzz_rise(200, t1);
        wait_buzz_rise(200, t2);
        check(t1 >= 0 && t2 >= 0 && (t2 - t1) == exp_buzz_cycles(d[5:4]),
              "R9 buzzer period", t2 - t1, exp_buzz_cycles(d[5:4]));
      end else begin
        quiet = 1'b1;
        for (int k = 0; k < 80; k++) begin
          @(negedge clk);
          if (buzz_o) quiet = 1'b0;
        end
        check(quiet, "R10 buzzer held low", !quiet, 0);
      end
    end

    // R5 + R7: normal interval from subsystem ticks
    wr(8'h00);
    wr(8'h05);
    t0 = cyc;
    wait_irq(70000, t1);
    check(t1 >= 0 && (t1 - t0) >= 16384 * SUB_CYC - 6 && (t1 - t0) <= 16384 * SUB_CYC + 6,
          "R5 normal interval", t1 - t0, 16384 * SUB_CYC);
    @(negedge clk);
    check(irq_o == 1'b0, "R7 pulse width normal", irq_o, 0);

    summary();
  end

endmodule